// File: doc/BRIEF.md
# Back-to-back equal-sample counter

This block watches a parallel data bus and counts how often the same value appears on two adjacent sampling edges. On every falling clock edge it takes a new sample of the bus. It compares that sample with the one held from the edge before. When the two are equal it adds one to a small wrapping counter. The same edge then replaces the held sample with the new one. Because of this, a run of N identical samples adds N-1 to the count.

The count is read directly from a register. Its value changes only at a falling edge. A synchronous reset clears the count. During reset the held sample keeps loading the bus, so the first compare after reset is made against the last value seen while reset was high.

Top module: `pair_match_counter`

## Requirements
- R1: The data input is DATA_W bits wide (default 8) and the count output is CNT_W bits wide (default 4).
- R2: When reset is low and the bus value sampled at a falling edge equals the value sampled at the previous falling edge, the count increases by one at that edge.
- R3: The count wraps: when the count is all ones (15 by default) and a match occurs, the count becomes 0.
- R4: When reset is high at a falling edge, the count becomes 0 at that edge. Raising reset between falling edges does not change the count before the next falling edge.
- R5: All state changes happen only on the falling clock edge. The count does not change at a rising edge.
- R6: The compare uses the held sample as it was before the edge. The held sample then takes the new bus value at that same edge.
- R7: While reset is high the held sample still loads the bus. The first compare after reset is made against the last value sampled during reset.
- R8: When reset is low and the two samples differ, the count keeps its value.
- R9: The count output comes only from a register. Changing the data input between falling edges does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; falling edge is the active edge |
| srst | input | 1 | Synchronous reset, active high |
| data_in | input | DATA_W | Bus being sampled |
| match_cnt | output | CNT_W | Wrapping count of equal adjacent samples |

## Verification
The assertions check on every falling edge that a match adds one to the count, that a mismatch leaves it unchanged, that the count wraps from all ones to zero, that the held sample equals the previous bus value, and that the count is zero after reset. Some behaviour can only be shown by the bench's scenarios. This covers a reset raised between edges having no effect until the falling edge, and the output staying still across rising edges and mid-cycle changes on the data input. It also covers the first compare after reset using the value sampled during reset.

// File: rtl/pair_match_counter.sv
module pair_match_counter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              srst,
  input  logic [DATA_W-1:0] data_in,
  output logic [CNT_W-1:0]  match_cnt
);

  logic [DATA_W-1:0] prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              same;

  assign same      = (data_in == prev_q);
  assign match_cnt = cnt_q;

  always_ff @(negedge clk) begin
    prev_q <= data_in;
    if (srst)
      cnt_q <= '0;
    else if (same)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pair_match_counter_chk.sv
module pair_match_counter_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              srst,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] prev_q,
  input logic [CNT_W-1:0]  cnt
);

  a_r2_count_on_match: assert property (@(negedge clk) disable iff (srst)
    (data_in == prev_q) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r8_hold_on_mismatch: assert property (@(negedge clk) disable iff (srst)
    (data_in != prev_q) |=> $stable(cnt));

  a_r3_wrap_to_zero: assert property (@(negedge clk) disable iff (srst)
    ((cnt == {CNT_W{1'b1}}) && (data_in == prev_q)) |=> (cnt == '0));

  a_r6_sample_reload: assert property (@(negedge clk) disable iff (srst)
    1'b1 |=> (prev_q == $past(data_in)));

  a_r4_reset_cleared: assert property (@(negedge clk) disable iff (srst)
    $fell(srst) |-> (cnt == '0));

endmodule

bind pair_match_counter pair_match_counter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .srst(srst), .data_in(data_in), .prev_q(prev_q), .cnt(match_cnt)
);

// File: tb/tb_pair_match_counter.sv
module tb_pair_match_counter;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b1;
  logic          srst = 1'b1;
  logic [DW-1:0] data_in = '0;
  logic [CW-1:0] match_cnt;

  int vectors = 0;
  int errors  = 0;
  int hist[$];
  int model_cnt = 0;

  always #2.5 clk = ~clk;

  pair_match_counter #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .srst(srst), .data_in(data_in), .match_cnt(match_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: match_cnt=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after the rising edge, check after the falling edge.
  task automatic step(input int d, input bit r, input string req);
    @(posedge clk); #1;
    check("R5 rising edge", match_cnt, model_cnt);
    data_in = DW'(d);
    srst = r;
    #0.5;
    check("R9 input change", match_cnt, model_cnt);
    @(negedge clk); #1;
    if (r) begin
      model_cnt = 0;
      hist.delete();
    end else if (hist.size() > 0 && hist[$] == d) begin
      model_cnt = (model_cnt + 1) % (1 << CW);
    end
    hist.push_back(d);
    if (hist.size() > 4) void'(hist.pop_front());
    check(req, match_cnt, model_cnt);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: match_cnt=%0d expected=finish", match_cnt);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) step(0, 1'b1, "R4 reset");
    check("R1 reset state", match_cnt, 0);
    // R7: first sample 0 after reset matches the 0 held during reset
    step(0, 1'b0, "R7 first compare after reset");
    step(0, 1'b0, "R2 repeat");
    step(7, 1'b0, "R8 mismatch");
    step(7, 1'b0, "R6 compare with old sample");
    for (int i = 0; i < 6; i++) step((i % 2) ? 8'hA5 : 8'h5A, 1'b0, "R8 alternating");
    for (int i = 0; i < 20; i++) step(8'hFF, 1'b0, "R3 wrap run");
    // R4: reset raised after rising edge: count unchanged until falling edge
    @(posedge clk); #1;
    srst = 1'b1; data_in = 8'h3C;
    #0.5;
    check("R4 no clear before falling edge", match_cnt, model_cnt);
    @(negedge clk); #1;
    model_cnt = 0; hist.delete(); hist.push_back(8'h3C);
    check("R4 cleared at falling edge", match_cnt, 0);
    step(8'h3C, 1'b1, "R4 reset held");
    step(8'h3C, 1'b0, "R7 match vs value sampled in reset");
    step(8'h11, 1'b1, "R4 reset");
    step(8'h22, 1'b0, "R7 mismatch vs value sampled in reset");
    for (int i = 0; i < 300; i++) begin
      int d;
      d = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 255)) : (hist.size() > 0 ? hist[$] : 0);
      step(d, ($urandom_range(0, 60) == 0), "R2 random");
    end
    for (int i = 0; i < 40; i++) step(8'h80 | (i / 5), 1'b0, "R2 runs");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule